// File: doc/BRIEF.md
# Pulse-Width Bus Symbol Receiver

This block turns a two-level pulse-width-modulated serial bus into bytes and frame markers. It counts a 1 µs strobe supplied by the surrounding logic to time each dominant pulse and each passive gap. Each dominant pulse is sorted into one of four symbol classes: start-of-frame, data one, data zero, or break. Each passive stretch is sorted into end-of-data, end-of-frame or idle. Every symbol class has its own receive tolerance window, and a width that lands in none of them is reported as a symbol error.

Data bits are shifted in most significant bit first. Every eighth bit yields a byte. After end-of-data, a new dominant edge before end-of-frame is taken as the start of an in-frame response, and its bytes follow on the same byte output. Ahead of all timing, the raw input goes through a three-sample majority vote taken on the 1 µs strobe, which removes single-sample glitches.

Top module: `pwm_sym_rx`

## Requirements
- R1: A dominant or passive excursion of `bus_in` (1 = dominant) that lasts a single 1 µs sample is removed by the majority vote and produces no symbol, byte or flag.
- R2: Inside a frame, a dominant pulse of 5 to 12 µs is a data 1 and one of 13 to 20 µs is a data 0. Bits are packed most significant first into `byte_data`.
- R3: Outside a frame, a dominant pulse of 29 to 36 µs opens a frame and pulses `sof_seen`. The start symbol's period, from its rising edge to the next rising edge, must be 45 to 52 µs, otherwise `sym_err` pulses. A start-width pulse inside a frame is an error.
- R4: A dominant pulse of 37 to 44 µs pulses `brk_seen` wherever it occurs and abandons any frame in progress, so no end-of-frame follows for that frame.
- R5: A dominant pulse whose width is in no window (below 5, 21 to 28, or above 44 µs) pulses `sym_err`. The frame is discarded, and later data bits yield no bytes until a new start symbol.
- R6: Inside a frame, each data bit period (rising edge to next rising edge) must be 21 to 28 µs, otherwise `sym_err` pulses and the frame is discarded.
- R7: When 43 µs pass since the last data bit's rising edge with the bus passive, `eod_seen` pulses if a whole number of bytes was received. If a partial byte is pending, `sym_err` pulses instead.
- R8: After end-of-data, 69 µs without a dominant edge pulses `eof_seen` and closes the frame. `bus_idle` is high once the bus has been passive for 86 µs or more since the last rising edge, and it goes low when dominant activity resumes.
- R9: Each completed byte is presented with `byte_valid` high for exactly one clock cycle.
- R10: Valid data-width pulses received while no frame is open are ignored: no byte and no error.
- R11: A dominant edge arriving after end-of-data and before end-of-frame starts an in-frame response. Its bits form further bytes, followed by a second end-of-data and then end-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle strobe every 1 µs |
| bus_in | input | 1 | Digitized bus level, 1 = dominant |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | BYTE_W | Received byte, first bit in the MSB |
| sof_seen | output | 1 | Start-of-frame pulse |
| eod_seen | output | 1 | End-of-data pulse |
| eof_seen | output | 1 | End-of-frame pulse |
| brk_seen | output | 1 | Break symbol pulse |
| sym_err | output | 1 | Symbol, timing or framing error pulse |
| bus_idle | output | 1 | Bus passive for the idle time |

## Verification
Frames are built from random bytes, with each bit's dominant width and period drawn at random inside its window. This shows that classification depends on the width window and not on a nominal value. Directed frames place widths and periods on both edges of every window, including the two start-symbol periods and an in-frame response after end-of-data. These distinguish accepted boundaries from the first rejected value. Separate patterns inject one value just outside each window, a break mid-frame, a partial byte before the gap, data with no open frame, and one-sample glitches. Each of these must yield its own flag and nothing else.

// File: rtl/pwm_rx_pkg.sv
`timescale 1ns/1ps
package pwm_rx_pkg;
  // receive windows, in microseconds
  localparam int ONE_MIN     = 5;
  localparam int ONE_MAX     = 12;
  localparam int ZERO_MIN    = 13;
  localparam int ZERO_MAX    = 20;
  localparam int SOF_MIN     = 29;
  localparam int SOF_MAX     = 36;
  localparam int BRK_MIN     = 37;
  localparam int BRK_MAX     = 44;
  localparam int BIT_PER_MIN = 21;
  localparam int BIT_PER_MAX = 28;
  localparam int SOF_PER_MIN = 45;
  localparam int SOF_PER_MAX = 52;
  localparam int EOD_AT      = 43;
  localparam int EOF_AT      = 69;
  localparam int IDLE_AT     = 86;

  typedef enum logic [2:0] {K_NONE, K_ONE, K_ZERO, K_SOF, K_BRK, K_BAD} sym_kind_t;
  typedef enum logic {ST_WAIT, ST_FRAME} frm_state_t;
endpackage

// File: rtl/pwm_rx_filter.sv
`timescale 1ns/1ps
module pwm_rx_filter #(
  parameter int TAPS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_in,
  input  logic raw,
  output logic filt,
  output logic rise,
  output logic fall,
  output logic adv
);
  localparam int HW   = TAPS - 1;
  localparam int HALF = TAPS / 2;

  logic [HW-1:0]   hist;
  logic [TAPS-1:0] win;
  logic            maj;

  assign win = {hist, raw};
  always_comb maj = ($countones(win) > HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      filt <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
      adv  <= 1'b0;
    end else begin
      adv  <= adv_in;
      rise <= 1'b0;
      fall <= 1'b0;
      if (adv_in) begin
        hist <= win[HW-1:0];
        filt <= maj;
        rise <= maj & ~filt;
        fall <= ~maj & filt;
      end
    end
  end
endmodule

// File: rtl/pwm_rx_timer.sv
`timescale 1ns/1ps
module pwm_rx_timer
  import pwm_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             filt,
  input  logic             rise,
  input  logic             fall,
  output logic             fall_ev,
  output sym_kind_t        fall_kind,
  output logic             rise_ev,
  output logic [CNT_W-1:0] period,
  output logic             low_ev,
  output logic [CNT_W-1:0] low_cnt,
  output logic             idle
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt, cnt_n;
  int               cnt_i, cnt_ni;
  sym_kind_t        kind_c;

  assign cnt_n  = (cnt == CMAX) ? cnt : cnt + 1'b1;
  assign cnt_i  = int'(cnt);
  assign cnt_ni = int'(cnt_n);

  // width of the pulse that just ended is the count of dominant samples
  always_comb begin
    if (cnt_i >= ONE_MIN && cnt_i <= ONE_MAX)        kind_c = K_ONE;
    else if (cnt_i >= ZERO_MIN && cnt_i <= ZERO_MAX) kind_c = K_ZERO;
    else if (cnt_i >= SOF_MIN && cnt_i <= SOF_MAX)   kind_c = K_SOF;
    else if (cnt_i >= BRK_MIN && cnt_i <= BRK_MAX)   kind_c = K_BRK;
    else                                             kind_c = K_BAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      fall_ev   <= 1'b0;
      fall_kind <= K_NONE;
      rise_ev   <= 1'b0;
      period    <= '0;
      low_ev    <= 1'b0;
      low_cnt   <= '0;
      idle      <= 1'b0;
    end else begin
      fall_ev <= 1'b0;
      rise_ev <= 1'b0;
      low_ev  <= 1'b0;
      if (adv) begin
        idle <= ~filt && (cnt_ni >= IDLE_AT);
        if (rise) begin
          rise_ev <= 1'b1;
          period  <= cnt;
          cnt     <= CNT_W'(1);
        end else begin
          cnt <= cnt_n;
          if (fall) begin
            fall_ev   <= 1'b1;
            fall_kind <= kind_c;
          end else if (!filt) begin
            low_ev  <= 1'b1;
            low_cnt <= cnt_n;
          end
        end
      end
    end
  end

  a_r8_idle_after_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> (low_ev && int'(low_cnt) >= IDLE_AT));
  a_r2_class_after_edge: assert property (@(posedge clk) disable iff (rst)
    fall_ev |-> $past(fall && adv));
endmodule

// File: rtl/pwm_rx_frame.sv
`timescale 1ns/1ps
module pwm_rx_frame
  import pwm_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_ev,
  input  sym_kind_t         fall_kind,
  input  logic              rise_ev,
  input  logic [CNT_W-1:0]  period,
  input  logic              low_ev,
  input  logic [CNT_W-1:0]  low_cnt,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              sof_o,
  output logic              eod_o,
  output logic              eof_o,
  output logic              brk_o,
  output logic              err_o
);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

  frm_state_t        st;
  logic              last_sof;
  logic              after_eod;
  logic [BC_W-1:0]   bitcnt;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              bit_v;
  logic              per_bad;
  int                per_i, low_i;

  assign per_i = int'(period);
  assign low_i = int'(low_cnt);
  assign bit_v = (fall_kind == K_ONE);
  assign sh_n  = {sh[BYTE_W-2:0], bit_v};
  assign per_bad = last_sof ? (per_i < SOF_PER_MIN || per_i > SOF_PER_MAX)
                            : (per_i < BIT_PER_MIN || per_i > BIT_PER_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_WAIT;
      last_sof   <= 1'b0;
      after_eod  <= 1'b0;
      bitcnt     <= '0;
      sh         <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      sof_o      <= 1'b0;
      eod_o      <= 1'b0;
      eof_o      <= 1'b0;
      brk_o      <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      sof_o      <= 1'b0;
      eod_o      <= 1'b0;
      eof_o      <= 1'b0;
      brk_o      <= 1'b0;
      err_o      <= 1'b0;
      if (fall_ev) begin
        unique case (fall_kind)
          K_BRK: begin
            brk_o <= 1'b1;
            st    <= ST_WAIT;
          end
          K_SOF: begin
            if (st == ST_WAIT) begin
              sof_o     <= 1'b1;
              st        <= ST_FRAME;
              bitcnt    <= '0;
              last_sof  <= 1'b1;
              after_eod <= 1'b0;
            end else begin
              err_o <= 1'b1;
              st    <= ST_WAIT;
            end
          end
          K_ONE, K_ZERO: begin
            if (st == ST_FRAME) begin
              sh       <= sh_n;
              bitcnt   <= bitcnt + 1'b1;
              last_sof <= 1'b0;
              if (bitcnt == BC_LAST) begin
                byte_valid <= 1'b1;
                byte_data  <= sh_n;
              end
            end
          end
          default: begin
            err_o <= 1'b1;
            st    <= ST_WAIT;
          end
        endcase
      end else if (rise_ev && st == ST_FRAME) begin
        if (after_eod) begin
          after_eod <= 1'b0;
        end else if (per_bad) begin
          err_o <= 1'b1;
          st    <= ST_WAIT;
        end
      end else if (low_ev && st == ST_FRAME) begin
        if (last_sof) begin
          if (low_i == SOF_PER_MAX + 1) begin
            err_o <= 1'b1;
            st    <= ST_WAIT;
          end
        end else if (!after_eod && low_i == EOD_AT) begin
          if (bitcnt != '0) begin
            err_o <= 1'b1;
            st    <= ST_WAIT;
          end else begin
            eod_o     <= 1'b1;
            after_eod <= 1'b1;
          end
        end else if (after_eod && low_i == EOF_AT) begin
          eof_o <= 1'b1;
          st    <= ST_WAIT;
        end
      end
    end
  end

  a_r9_byte_one_cycle: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
  a_r5_err_drops_frame: assert property (@(posedge clk) disable iff (rst)
    err_o |-> st == ST_WAIT);
  a_r8_eof_closes: assert property (@(posedge clk) disable iff (rst)
    eof_o |-> st == ST_WAIT);
  a_r7_eod_whole_bytes: assert property (@(posedge clk) disable iff (rst)
    eod_o |-> (st == ST_FRAME && bitcnt == '0));
  a_r3_sof_opens: assert property (@(posedge clk) disable iff (rst)
    sof_o |-> (st == ST_FRAME && bitcnt == '0 && $past(st) == ST_WAIT));
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sof_o, eod_o, eof_o, brk_o, err_o}));
endmodule

// File: rtl/pwm_sym_rx.sv
`timescale 1ns/1ps
module pwm_sym_rx
  import pwm_rx_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int FILT_TAPS = 3,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              bus_in,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              sof_seen,
  output logic              eod_seen,
  output logic              eof_seen,
  output logic              brk_seen,
  output logic              sym_err,
  output logic              bus_idle
);
  logic             filt, rise, fall, adv;
  logic             fall_ev, rise_ev, low_ev;
  sym_kind_t        fall_kind;
  logic [CNT_W-1:0] period, low_cnt;

  pwm_rx_filter #(.TAPS(FILT_TAPS)) u_filt (
    .clk(clk), .rst(rst), .adv_in(tick_us), .raw(bus_in),
    .filt(filt), .rise(rise), .fall(fall), .adv(adv)
  );

  pwm_rx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .adv(adv), .filt(filt), .rise(rise), .fall(fall),
    .fall_ev(fall_ev), .fall_kind(fall_kind), .rise_ev(rise_ev), .period(period),
    .low_ev(low_ev), .low_cnt(low_cnt), .idle(bus_idle)
  );

  pwm_rx_frame #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst(rst), .fall_ev(fall_ev), .fall_kind(fall_kind),
    .rise_ev(rise_ev), .period(period), .low_ev(low_ev), .low_cnt(low_cnt),
    .byte_valid(byte_valid), .byte_data(byte_data), .sof_o(sof_seen),
    .eod_o(eod_seen), .eof_o(eof_seen), .brk_o(brk_seen), .err_o(sym_err)
  );
endmodule

// File: tb/pwm_sym_rx_tb_top.sv
`timescale 1ns/1ps
module pwm_sym_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_us = 1'b0;
  logic       bus_in = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       sof_seen, eod_seen, eof_seen, brk_seen, sym_err, bus_idle;

  always #2 clk = ~clk;

  pwm_sym_rx dut_i (
    .clk(clk), .rst(rst), .tick_us(tick_us), .bus_in(bus_in),
    .byte_valid(byte_valid), .byte_data(byte_data), .sof_seen(sof_seen),
    .eod_seen(eod_seen), .eof_seen(eof_seen), .brk_seen(brk_seen),
    .sym_err(sym_err), .bus_idle(bus_idle)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  int c_sof = 0, c_eod = 0, c_eof = 0, c_brk = 0, c_err = 0, c_multi = 0;
  int b_sof, b_eod, b_eof, b_brk, b_err, b_byte;
  logic prev_v = 1'b0;
  logic [7:0] got[$];
  logic [7:0] exp_q[$];
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid) got.push_back(byte_data);
      if (byte_valid && prev_v) c_multi++;
      prev_v = byte_valid;
      if (sof_seen) c_sof++;
      if (eod_seen) c_eod++;
      if (eof_seen) c_eof++;
      if (brk_seen) c_brk++;
      if (sym_err)  c_err++;
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      summary();
      $finish;
    end
  end

  task automatic step(bit lvl);
    bus_in = lvl;
    repeat (3) @(negedge clk);
    tick_us = 1'b1;
    @(negedge clk);
    tick_us = 1'b0;
  endtask

  task automatic hold(bit lvl, int n);
    for (int i = 0; i < n; i++) step(lvl);
  endtask

  task automatic sym(int w, int p);
    hold(1'b1, w);
    hold(1'b0, p - w);
  endtask

  function automatic int rnd_w(bit b);
    return b ? 5 + int'($urandom % 8) : 13 + int'($urandom % 8);
  endfunction

  task automatic rnd_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      int w, lo, p;
      w  = rnd_w(v[i]);
      lo = (w + 3 > 21) ? w + 3 : 21;
      p  = lo + int'($urandom % (29 - lo));
      sym(w, p);
    end
  endtask

  // boundary widths and periods; the last bit (i = 0) always has period 21
  task automatic edge_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      bit odd;
      odd = i[0];
      if (v[i]) sym(odd ? 12 : 5, odd ? 28 : 21);
      else      sym(odd ? 20 : 13, odd ? 28 : 21);
    end
  endtask

  task automatic snap();
    b_sof = c_sof; b_eod = c_eod; b_eof = c_eof;
    b_brk = c_brk; b_err = c_err; b_byte = got.size();
    exp_q.delete();
  endtask

  task automatic check_bytes(string req);
    check(got.size() - b_byte == exp_q.size(), {req, " byte count"},
          got.size() - b_byte, exp_q.size());
    for (int i = 0; i < exp_q.size() && b_byte + i < got.size(); i++)
      check(got[b_byte + i] == exp_q[i], {req, " byte value"},
            got[b_byte + i], exp_q[i]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    check(byte_valid == 1'b0, "R9 reset byte_valid", byte_valid, 0);
    check(bus_idle == 1'b0, "R8 reset idle", bus_idle, 0);
    check(sym_err == 1'b0, "R5 reset err", sym_err, 0);

    // R8: idle after long passive, drops on dominant
    hold(1'b0, 90);
    check(bus_idle == 1'b1, "R8 idle after 86us", bus_idle, 1);
    snap();
    hold(1'b1, 10);
    check(bus_idle == 1'b0, "R8 idle drops", bus_idle, 0);
    hold(1'b0, 90);
    // R10: the lone data pulse above made nothing
    check(c_err == b_err && got.size() == b_byte, "R10 lone pulse", c_err - b_err, 0);

    // directed boundary frame with in-frame response (R2 R3 R7 R8 R11)
    snap();
    sym(29, 45);
    edge_byte(8'hA5); exp_q.push_back(8'hA5);
    edge_byte(8'h3C); exp_q.push_back(8'h3C);
    hold(1'b0, 48 - 21);
    edge_byte(8'h96); exp_q.push_back(8'h96);
    hold(1'b0, 90);
    check_bytes("R2");
    check(c_sof - b_sof == 1, "R3 sof count", c_sof - b_sof, 1);
    check(c_eod - b_eod == 2, "R11 eod count with response", c_eod - b_eod, 2);
    check(c_eof - b_eof == 1, "R8 eof count", c_eof - b_eof, 1);
    check(c_err == b_err, "R7 no error", c_err - b_err, 0);

    // R3: upper start-symbol boundary
    snap();
    sym(36, 52);
    edge_byte(8'hFF); exp_q.push_back(8'hFF);
    edge_byte(8'h00); exp_q.push_back(8'h00);
    hold(1'b0, 90);
    check_bytes("R3");
    check(c_err == b_err && c_eof - b_eof == 1, "R3 sof 36/52 accepted", c_err - b_err, 0);

    // random frames (R2 R9)
    for (int f = 0; f < 20; f++) begin
      int nb;
      snap();
      nb = 1 + int'($urandom % 4);
      sym(29 + int'($urandom % 8), 45 + int'($urandom % 8));
      for (int k = 0; k < nb; k++) begin
        logic [7:0] v;
        v = 8'($urandom);
        exp_q.push_back(v);
        rnd_byte(v);
      end
      hold(1'b0, 90);
      check_bytes("R2 random");
      check(c_eof - b_eof == 1 && c_err == b_err, "R8 random eof", c_eof - b_eof, 1);
    end
    check(c_multi == 0, "R9 one-cycle strobe", c_multi, 0);

    // R1: single-sample glitches
    snap();
    hold(1'b1, 1);
    hold(1'b0, 90);
    check(c_err == b_err && c_sof == b_sof && c_brk == b_brk, "R1 dominant glitch", c_err - b_err, 0);
    snap();
    sym(30, 48);
    hold(1'b1, 5); hold(1'b0, 1); hold(1'b1, 6); hold(1'b0, 12);
    for (int i = 0; i < 7; i++) sym(7, 24);
    exp_q.push_back(8'hFF);
    hold(1'b0, 90);
    check_bytes("R1 passive glitch");
    check(c_err == b_err, "R1 passive glitch no error", c_err - b_err, 0);

    // R5: widths in no window
    snap();
    sym(30, 48);
    sym(7, 24); sym(7, 24); sym(7, 24);
    sym(4, 24);
    for (int i = 0; i < 8; i++) sym(15, 24);
    hold(1'b0, 90);
    check(c_err - b_err == 1, "R5 width 4 error", c_err - b_err, 1);
    check(got.size() == b_byte && c_eof == b_eof, "R5 frame discarded", got.size() - b_byte, 0);
    snap();
    sym(30, 48);
    sym(24, 28);
    hold(1'b0, 90);
    check(c_err - b_err == 1, "R5 width 24 error", c_err - b_err, 1);
    snap();
    sym(45, 60);
    hold(1'b0, 90);
    check(c_err - b_err == 1, "R5 width 45 error", c_err - b_err, 1);

    // R4: break mid-frame and outside a frame
    snap();
    sym(30, 48);
    edge_byte(8'h5A); exp_q.push_back(8'h5A);
    sym(40, 48);
    for (int i = 0; i < 8; i++) sym(7, 24);
    hold(1'b0, 90);
    check(c_brk - b_brk == 1, "R4 break flagged", c_brk - b_brk, 1);
    check(c_eof == b_eof && c_err == b_err, "R4 no eof after break", c_eof - b_eof, 0);
    check_bytes("R4");
    snap();
    sym(37, 50); sym(44, 50);
    hold(1'b0, 90);
    check(c_brk - b_brk == 2, "R4 idle breaks", c_brk - b_brk, 2);

    // R6: bit period out of window
    snap();
    sym(30, 48);
    sym(7, 24); sym(7, 30);
    for (int i = 0; i < 8; i++) sym(7, 24);
    hold(1'b0, 90);
    check(c_err - b_err == 1 && got.size() == b_byte, "R6 period 30", c_err - b_err, 1);
    snap();
    sym(30, 48);
    sym(7, 20);
    hold(1'b0, 90);
    check(c_err - b_err == 1, "R6 period 20", c_err - b_err, 1);

    // R7: partial byte before gap
    snap();
    sym(30, 48);
    for (int i = 0; i < 4; i++) sym(7, 24);
    hold(1'b0, 90);
    check(c_err - b_err == 1, "R7 partial byte error", c_err - b_err, 1);
    check(c_eod == b_eod && c_eof == b_eof, "R7 no eod", c_eod - b_eod, 0);

    // R3: start-symbol period and width errors
    snap();
    sym(32, 44);
    hold(1'b0, 90);
    check(c_err - b_err == 1 && c_sof - b_sof == 1, "R3 sof period 44", c_err - b_err, 1);
    snap();
    sym(32, 53);
    for (int i = 0; i < 8; i++) sym(7, 24);
    hold(1'b0, 90);
    check(c_err - b_err == 1 && got.size() == b_byte, "R3 sof period 53", c_err - b_err, 1);
    snap();
    sym(30, 48);
    sym(30, 48);
    hold(1'b0, 90);
    check(c_err - b_err == 1 && c_sof - b_sof == 1, "R3 sof inside frame", c_err - b_err, 1);

    // R10: data with no frame open
    snap();
    for (int i = 0; i < 16; i++) sym(7 + 8 * (i % 2), 24);
    hold(1'b0, 90);
    check(got.size() == b_byte, "R10 no bytes", got.size() - b_byte, 0);
    check(c_err == b_err && c_eod == b_eod, "R10 no flags", c_err - b_err, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule